// File: doc/BRIEF.md
# Security Configuration Register with Level-Based Access Control

This block holds the 32-bit word that configures the security behaviour of a processor core: which security world the core runs in, where interrupts and external aborts are routed, whether the core may suspend on wait instructions, and related controls. Each implemented field is driven out as its own signal for the surrounding core logic. Reserved bit positions are never stored, so they always read as zero and writes to them are discarded.

System-register requests arrive tagged with the requester's exception level and security state. Each request is resolved in the cycle it is presented, using a fixed table. Level 3 requests complete. Secure level 1 requests are turned into a trap toward level 3. Every other requester gets an undefined-instruction indication. The block also reports the effective security state. This is the non-secure field, except that monitor mode always counts as secure. Instruction decode and exception entry sit outside this block.

Top module: `sec_cfg_reg`

## Requirements
- R1: After reset every implemented field is 0, every field output is 0, and a level 3 read returns 0.
- R2: The implemented bits are 13, 12, 9, 8, 7, 5, 4, 3, 2, 1 and 0, giving the mask 0x000033BF. A completed write stores only these bits. Bits 31:14, 11:10 and 6 always read as 0.
- R3: A completed write appears on the field outputs and in reads from the next rising clock edge. During the write cycle the outputs still show the old value.
- R4: A request from level 1 with reqNonSec=0 asserts rspTrap in the same cycle. It does not complete, returns read data 0, and leaves the register unchanged.
- R5: Requests from level 0 (either state), from level 1 with reqNonSec=1, and from level 2 assert rspUndef. They return read data 0 and leave the register unchanged.
- R6: A request from level 3 asserts rspDone whatever the value of reqNonSec. A read returns the stored word in the same cycle.
- R7: effNonSecure is 1 only when the non-secure field (bit 0) is 1 and inMonitor is 0.
- R8: The field outputs map to bits as follows: trapWfe=13, trapWfi=12, secFetchGuard=9, hypCallEn=8, smcOff=7, abortMaskFree=5, fiqMaskFree=4, abortToMon=3, fiqToMon=2, irqToMon=1, nonSecBit=0.
- R9: With reqValid=0, rspDone, rspUndef and rspTrap are all 0, rspRdData is 0, and nothing is written.
- R10: At most one of rspDone, rspUndef and rspTrap is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLevel | input | 2 | Requester exception level |
| reqNonSec | input | 1 | Requester is in the non-secure state |
| reqWrData | input | 32 | Write data |
| inMonitor | input | 1 | Core is currently in monitor mode |
| rspDone | output | 1 | Request completed |
| rspUndef | output | 1 | Request rejected as undefined instruction |
| rspTrap | output | 1 | Request must trap to level 3 |
| rspRdData | output | 32 | Read data (0 unless completed read) |
| trapWfe | output | 1 | Trap suspending wait-for-event |
| trapWfi | output | 1 | Trap suspending wait-for-interrupt |
| secFetchGuard | output | 1 | Block secure fetches from non-secure memory |
| hypCallEn | output | 1 | Hypervisor call enabled |
| smcOff | output | 1 | Secure monitor call disabled in non-secure state |
| abortMaskFree | output | 1 | Abort mask writable in any state |
| fiqMaskFree | output | 1 | Fast interrupt mask writable in any state |
| abortToMon | output | 1 | External aborts routed to monitor |
| fiqToMon | output | 1 | Fast interrupts routed to monitor |
| irqToMon | output | 1 | Interrupts routed to monitor |
| nonSecBit | output | 1 | Stored non-secure field |
| effNonSecure | output | 1 | Effective non-secure state |

## Verification
The response flags and read data are combinational, so they are due in the same cycle as the request. The bench drives each request on a falling edge and samples one time unit later, before the next rising edge. A completed write is due on the field outputs one rising edge later. The bench checks the old value inside the write cycle and the new value just after that edge. effNonSecure depends only on the stored bit and inMonitor, so it is checked in the same cycle the mode input changes.

// File: rtl/secCfgPkg.sv
package secCfgPkg;
  localparam int CFG_W = 32;
  localparam logic [CFG_W-1:0] CFG_IMPL_MASK = 32'h0000_33BF;

  localparam int B_WFE     = 13;
  localparam int B_WFI     = 12;
  localparam int B_SFETCH  = 9;
  localparam int B_HYP     = 8;
  localparam int B_SMCOFF  = 7;
  localparam int B_AMASK   = 5;
  localparam int B_FMASK   = 4;
  localparam int B_ABTMON  = 3;
  localparam int B_FIQMON  = 2;
  localparam int B_IRQMON  = 1;
  localparam int B_NS      = 0;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } cfgStrobeT;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_OK    = 2'd1,
    ACC_TRAP  = 2'd2,
    ACC_UNDEF = 2'd3
  } accClassT;
endpackage

// File: rtl/secCfgCtrl.sv
module secCfgCtrl
  import secCfgPkg::*;
#(
  parameter int LEVEL_W     = 2,
  parameter int ALLOW_LEVEL = 3,
  parameter int TRAP_LEVEL  = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [LEVEL_W-1:0] reqLevel,
  input  logic               reqNonSec,
  output cfgStrobeT          strobe,
  output logic               rspDone,
  output logic               rspUndef,
  output logic               rspTrap
);
  localparam logic [LEVEL_W-1:0] LVL_ALLOW = LEVEL_W'(ALLOW_LEVEL);
  localparam logic [LEVEL_W-1:0] LVL_TRAP  = LEVEL_W'(TRAP_LEVEL);

  accClassT accClass;

  // Fixed access table: the top level always completes, secure trap level traps,
  // everyone else is rejected.
  always_comb begin
    accClass = ACC_IDLE;
    if (reqValid) begin
      if (reqLevel == LVL_ALLOW)
        accClass = ACC_OK;
      else if ((reqLevel == LVL_TRAP) && !reqNonSec)
        accClass = ACC_TRAP;
      else
        accClass = ACC_UNDEF;
    end
  end

  always_comb begin
    strobe.wrEn = (accClass == ACC_OK) &&  reqWrite;
    strobe.rdEn = (accClass == ACC_OK) && !reqWrite;
    rspDone     = (accClass == ACC_OK);
    rspTrap     = (accClass == ACC_TRAP);
    rspUndef    = (accClass == ACC_UNDEF);
  end

  // R10: responses are mutually exclusive
  p_resp_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspDone, rspUndef, rspTrap}));

  // R4: secure trap-level request must trap and never write
  p_secure_trap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqLevel == LVL_TRAP && !reqNonSec) |-> (rspTrap && !strobe.wrEn));

  // R9: idle cycle gives no response and no strobe
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(rspDone || rspUndef || rspTrap || strobe.wrEn || strobe.rdEn));

  // R6: allowed level always completes
  p_allow_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqLevel == LVL_ALLOW) |-> rspDone);
endmodule

// File: rtl/secCfgData.sv
module secCfgData
  import secCfgPkg::*;
#(
  parameter int               DATA_W    = CFG_W,
  parameter logic [DATA_W-1:0] IMPL_MASK = CFG_IMPL_MASK,
  parameter int               NS_BIT    = B_NS
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobeT         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              inMonitor,
  output logic [DATA_W-1:0] cfgWord,
  output logic [DATA_W-1:0] rdData,
  output logic              effNonSecure
);
  // One flop per implemented bit; reserved positions are tied to zero.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk) begin
        if (!rstN)
          q <= 1'b0;
        else if (strobe.wrEn)
          q <= wrData[i];
      end
      assign cfgWord[i] = q;
    end else begin : g_rsvd
      assign cfgWord[i] = 1'b0;
    end
  end

  assign rdData       = strobe.rdEn ? cfgWord : '0;
  assign effNonSecure = cfgWord[NS_BIT] && !inMonitor;

  // R3: a granted write lands on the next edge, masked
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> (cfgWord == ($past(wrData) & IMPL_MASK)));

  // R5: without a granted write the stored word holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(cfgWord));

  // R7: monitor mode is always reported secure
  p_monitor_secure_r7: assert property (@(posedge clk) disable iff (!rstN)
    inMonitor |-> !effNonSecure);
endmodule

// File: rtl/sec_cfg_reg.sv
module sec_cfg_reg
  import secCfgPkg::*;
#(
  parameter int LEVEL_W     = 2,
  parameter int ALLOW_LEVEL = 3,
  parameter int TRAP_LEVEL  = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [LEVEL_W-1:0] reqLevel,
  input  logic               reqNonSec,
  input  logic [CFG_W-1:0]   reqWrData,
  input  logic               inMonitor,
  output logic               rspDone,
  output logic               rspUndef,
  output logic               rspTrap,
  output logic [CFG_W-1:0]   rspRdData,
  output logic               trapWfe,
  output logic               trapWfi,
  output logic               secFetchGuard,
  output logic               hypCallEn,
  output logic               smcOff,
  output logic               abortMaskFree,
  output logic               fiqMaskFree,
  output logic               abortToMon,
  output logic               fiqToMon,
  output logic               irqToMon,
  output logic               nonSecBit,
  output logic               effNonSecure
);
  cfgStrobeT        strobe;
  logic [CFG_W-1:0] cfgWord;

  secCfgCtrl #(
    .LEVEL_W(LEVEL_W), .ALLOW_LEVEL(ALLOW_LEVEL), .TRAP_LEVEL(TRAP_LEVEL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLevel(reqLevel), .reqNonSec(reqNonSec), .strobe(strobe),
    .rspDone(rspDone), .rspUndef(rspUndef), .rspTrap(rspTrap)
  );

  secCfgData #(
    .DATA_W(CFG_W), .IMPL_MASK(CFG_IMPL_MASK), .NS_BIT(B_NS)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(reqWrData),
    .inMonitor(inMonitor), .cfgWord(cfgWord), .rdData(rspRdData),
    .effNonSecure(effNonSecure)
  );

  // R8: field fan-out
  assign trapWfe       = cfgWord[B_WFE];
  assign trapWfi       = cfgWord[B_WFI];
  assign secFetchGuard = cfgWord[B_SFETCH];
  assign hypCallEn     = cfgWord[B_HYP];
  assign smcOff        = cfgWord[B_SMCOFF];
  assign abortMaskFree = cfgWord[B_AMASK];
  assign fiqMaskFree   = cfgWord[B_FMASK];
  assign abortToMon    = cfgWord[B_ABTMON];
  assign fiqToMon      = cfgWord[B_FIQMON];
  assign irqToMon      = cfgWord[B_IRQMON];
  assign nonSecBit     = cfgWord[B_NS];

  // R2: reserved bits never reach the read port
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rspRdData & ~CFG_IMPL_MASK) == '0);
endmodule

// File: tb/tb_sec_cfg_reg.sv
module tb_sec_cfg_reg;
  localparam logic [31:0] MASK = 32'h0000_33BF;

  logic clk = 1'b0;
  logic rstN;
  logic reqValid, reqWrite, reqNonSec, inMonitor;
  logic [1:0] reqLevel;
  logic [31:0] reqWrData;
  logic rspDone, rspUndef, rspTrap;
  logic [31:0] rspRdData;
  logic trapWfe, trapWfi, secFetchGuard, hypCallEn, smcOff, abortMaskFree;
  logic fiqMaskFree, abortToMon, fiqToMon, irqToMon, nonSecBit, effNonSecure;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sec_cfg_reg dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLevel(reqLevel), .reqNonSec(reqNonSec), .reqWrData(reqWrData),
    .inMonitor(inMonitor), .rspDone(rspDone), .rspUndef(rspUndef),
    .rspTrap(rspTrap), .rspRdData(rspRdData), .trapWfe(trapWfe),
    .trapWfi(trapWfi), .secFetchGuard(secFetchGuard), .hypCallEn(hypCallEn),
    .smcOff(smcOff), .abortMaskFree(abortMaskFree), .fiqMaskFree(fiqMaskFree),
    .abortToMon(abortToMon), .fiqToMon(fiqToMon), .irqToMon(irqToMon),
    .nonSecBit(nonSecBit), .effNonSecure(effNonSecure)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Reassemble field outputs at their R8 bit positions
  function automatic logic [31:0] fieldWord();
    logic [31:0] w = '0;
    w[13] = trapWfe;       w[12] = trapWfi;    w[9] = secFetchGuard;
    w[8]  = hypCallEn;     w[7]  = smcOff;     w[5] = abortMaskFree;
    w[4]  = fiqMaskFree;   w[3]  = abortToMon; w[2] = fiqToMon;
    w[1]  = irqToMon;      w[0]  = nonSecBit;
    return w;
  endfunction

  // One request cycle: driven at negedge, checked 1 time unit later,
  // register effect checked just after the following posedge.
  task automatic doReq(input logic wr, input logic [1:0] lvl, input logic ns,
                       input logic [31:0] data);
    logic expDone, expTrap, expUndef;
    logic [31:0] expRd;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqLevel = lvl; reqNonSec = ns; reqWrData = data;
    #1;
    expDone  = (lvl == 2'd3);
    expTrap  = (lvl == 2'd1) && !ns;
    expUndef = !expDone && !expTrap;
    expRd    = (expDone && !wr) ? mdl : 32'h0;
    chk("R6 done", {31'b0, rspDone}, {31'b0, expDone});
    chk("R4 trap", {31'b0, rspTrap}, {31'b0, expTrap});
    chk("R5 undef", {31'b0, rspUndef}, {31'b0, expUndef});
    chk("R10 onehot", {31'b0, ($countones({rspDone, rspUndef, rspTrap}) <= 1)}, 32'h1);
    chk("R6 read data", rspRdData, expRd);
    chk("R3 old value in write cycle", fieldWord(), mdl);
    if (expDone && wr) mdl = data & MASK;
    @(posedge clk); #1;
    reqValid = 1'b0;
    chk("R2 R8 fields after edge", fieldWord(), mdl);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqLevel = 2'd0;
    reqNonSec = 1'b0; reqWrData = '0; inMonitor = 1'b0; mdl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1 reset fields", fieldWord(), 32'h0);
    chk("R1 reset eff", {31'b0, effNonSecure}, 32'h0);
    doReq(1'b0, 2'd3, 1'b0, 32'h0);

    // R9: idle with write data present changes nothing
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b1; reqLevel = 2'd3; reqWrData = 32'hFFFF_FFFF;
    #1;
    chk("R9 idle resp", {29'b0, rspDone, rspUndef, rspTrap}, 32'h0);
    chk("R9 idle rd", rspRdData, 32'h0);
    @(posedge clk); #1;
    chk("R9 idle no write", fieldWord(), mdl);

    // Sweep patterns over every level, state and direction
    for (int p = 0; p < 8; p++) begin
      logic [31:0] pat;
      case (p)
        0: pat = 32'hFFFF_FFFF;
        1: pat = 32'h0000_0000;
        2: pat = 32'hAAAA_AAAA;
        3: pat = 32'h5555_5555;
        default: pat = 32'h1357_9BDF * p + 32'h0F0F_3C3C;
      endcase
      for (int lv = 0; lv < 4; lv++) begin
        for (int n = 0; n < 2; n++) begin
          doReq(1'b1, 2'(lv), n[0], pat ^ (32'h0000_1111 * lv) ^ {31'b0, n[0]});
          doReq(1'b0, 2'(lv), n[0], 32'h0);
          doReq(1'b0, 2'd3, 1'b1, 32'h0);  // observe stored word
        end
      end
    end

    // R2: write all ones, reserved bits read 0
    doReq(1'b1, 2'd3, 1'b0, 32'hFFFF_FFFF);
    doReq(1'b0, 2'd3, 1'b0, 32'h0);
    chk("R2 mask", mdl, MASK);

    // R8: walk each implemented bit individually
    for (int b = 0; b < 32; b++) begin
      doReq(1'b1, 2'd3, 1'b0, 32'h1 << b);
    end

    // R7: effective state over NS x monitor
    for (int nsv = 0; nsv < 2; nsv++) begin
      doReq(1'b1, 2'd3, 1'b0, {31'b0, nsv[0]});
      for (int m = 0; m < 2; m++) begin
        @(negedge clk); inMonitor = m[0]; #1;
        chk("R7 effective state", {31'b0, effNonSecure}, {31'b0, nsv[0] && !m[0]});
      end
    end
    @(negedge clk); inMonitor = 1'b0;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule